// File: doc/BRIEF.md
# Timed Reset and Reset-Halt Sequencer

This block sits beside a debug control register file and turns two control-register write strobes into timed pulses. One pulse is the system reset, and the other asks for a halt after reset. The length of each pulse comes from a 3-bit exponent in the configuration register, so either pulse can last from 1 to 128 cycles.

When the halt-after-reset request is written in the same cycle as the reset, the block captures the current warp selection. Those warps are held halted while the halt pulse runs, and they stay halted with a recorded cause until the debugger resumes them. The configuration also carries an enable bit. When it is set, a warp that executes a breakpoint instruction is parked as halted.

Clearing the debug-enable input stops both pulses at once and wipes the per-warp halt state.

Top module: `rst_halt_seq`

## Requirements
- R1: After a reset write is accepted on a clock edge, `sysReset` is high for exactly 2^`rstExp` consecutive cycles, starting in the cycle after that edge.
- R2: A combined reset and reset-halt write drives `resetHaltReq` high for exactly 2^`haltExp` cycles.
- R3: The reset-halt pulse starts in the same cycle as the reset pulse it was written with.
- R4: A reset-halt write without a reset write in the same cycle is ignored. No pulse starts and no warp halts.
- R5: Warps whose `selMask` bit was set at the combined write become halted, with cause code 3'b100 in their 3-bit `haltCause` field (warp i at bits 3i+2:3i). Unselected warps are unaffected.
- R6: When `ebreakHaltEn` is 1, a running warp with `ebreakHit` set becomes halted with cause 3'b001. When `ebreakHaltEn` is 0, `ebreakHit` has no effect.
- R7: A reset write during a running reset pulse restarts the count with the current `rstExp`.
- R8: While `dmActive` is 0, both pulses are low from the next cycle on, every halted bit is cleared and every cause is 3'b000.
- R9: While the reset-halt pulse is not running, `resumeReq` clears the halted bit and cause (to 3'b000) of every warp in `selMask`.
- R10: Reset and reset-halt writes made while `dmActive` is 0 start no pulse.
- R11: After `rstN` is released, both pulses are low, no warp is halted and all causes are 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dmActive | input | 1 | Debug logic enable; 0 aborts and clears |
| rstExp | input | EXP_W | Reset pulse length exponent |
| haltExp | input | EXP_W | Reset-halt pulse length exponent |
| ebreakHaltEn | input | 1 | Let breakpoint instructions halt warps |
| resetWrite | input | 1 | Strobe: reset bit written as 1 |
| resetHaltWrite | input | 1 | Strobe: reset-halt bit written as 1 |
| resumeReq | input | 1 | Strobe: resume warps in selMask |
| selMask | input | NUM_WARPS | Warp selection |
| ebreakHit | input | NUM_WARPS | Per-warp breakpoint executed |
| sysReset | output | 1 | Timed reset pulse; also the readable reset status |
| resetHaltReq | output | 1 | Timed halt-after-reset request |
| haltedMask | output | NUM_WARPS | Per-warp halted state |
| haltCause | output | 3*NUM_WARPS | Per-warp halt cause codes |

## Verification
The assertions run on every cycle. They check that each pulse rises only after an accepted write, that a warp becomes halted only under the reset-halt pulse or an enabled breakpoint, that a halted bit and a nonzero cause always agree, and that dropping `dmActive` silences both pulses on the next cycle. The exact pulse lengths, the restart arithmetic, the selection of affected warps and the ignored-write cases can only be shown by the bench. It sweeps all 64 pairs of exponents, compares the counted lengths with powers of two, and follows each scenario at the ports.

// File: rtl/rst_halt_seq_pkg.sv
package rst_halt_seq_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'b000,
    CAUSE_EBREAK  = 3'b001,
    CAUSE_HALTREQ = 3'b010,
    CAUSE_STEP    = 3'b011,
    CAUSE_RSTHALT = 3'b100
  } haltCause_e;

  typedef struct packed {
    logic loadRst;
    logic loadHalt;
    logic abort;
    logic resume;
    logic ebreakOk;
  } seqStrobe_t;

endpackage

// File: rtl/rst_halt_seq_ctrl.sv
module rst_halt_seq_ctrl
  import rst_halt_seq_pkg::*;
(
  input  logic       dmActive,
  input  logic       resetWrite,
  input  logic       resetHaltWrite,
  input  logic       resumeReq,
  input  logic       ebreakHaltEn,
  output seqStrobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.abort    = !dmActive;
    // a reset-halt write only counts alongside a reset write
    strobe.loadRst  = dmActive && resetWrite;
    strobe.loadHalt = dmActive && resetWrite && resetHaltWrite;
    strobe.resume   = dmActive && resumeReq;
    strobe.ebreakOk = dmActive && ebreakHaltEn;
  end

endmodule

// File: rtl/rst_halt_seq_dp.sv
module rst_halt_seq_dp
  import rst_halt_seq_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int EXP_W     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strobe,
  input  logic [EXP_W-1:0]       rstExp,
  input  logic [EXP_W-1:0]       haltExp,
  input  logic [NUM_WARPS-1:0]   selMask,
  input  logic [NUM_WARPS-1:0]   ebreakHit,
  output logic                   sysReset,
  output logic                   resetHaltReq,
  output logic [NUM_WARPS-1:0]   haltedMask,
  output logic [3*NUM_WARPS-1:0] haltCause
);

  // largest length is 2^(2^EXP_W - 1), which needs 2^EXP_W bits
  localparam int CNT_W = 1 << EXP_W;

  logic [CNT_W-1:0]     rstCnt;
  logic [CNT_W-1:0]     haltCnt;
  logic [NUM_WARPS-1:0] armMask;
  logic                 haltActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (strobe.abort) begin
      rstCnt <= '0;
    end else if (strobe.loadRst) begin
      rstCnt <= CNT_W'(1) << rstExp;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltCnt <= '0;
      armMask <= '0;
    end else if (strobe.abort) begin
      haltCnt <= '0;
      armMask <= '0;
    end else if (strobe.loadHalt) begin
      haltCnt <= CNT_W'(1) << haltExp;
      armMask <= selMask;
    end else if (haltCnt != '0) begin
      haltCnt <= haltCnt - CNT_W'(1);
    end
  end

  assign haltActive   = (haltCnt != '0);
  assign sysReset     = (rstCnt != '0);
  assign resetHaltReq = haltActive;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : gWarp
    logic       halted;
    haltCause_e cause;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        halted <= 1'b0;
        cause  <= CAUSE_NONE;
      end else if (strobe.abort) begin
        halted <= 1'b0;
        cause  <= CAUSE_NONE;
      end else if (haltActive && armMask[w]) begin
        halted <= 1'b1;
        cause  <= CAUSE_RSTHALT;
      end else if (strobe.ebreakOk && ebreakHit[w] && !halted) begin
        halted <= 1'b1;
        cause  <= CAUSE_EBREAK;
      end else if (strobe.resume && selMask[w] && !haltActive) begin
        halted <= 1'b0;
        cause  <= CAUSE_NONE;
      end
    end

    assign haltedMask[w]          = halted;
    assign haltCause[3*w +: 3]    = cause;
  end

endmodule

// File: rtl/rst_halt_seq.sv
module rst_halt_seq
  import rst_halt_seq_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  parameter int EXP_W     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dmActive,
  input  logic [EXP_W-1:0]       rstExp,
  input  logic [EXP_W-1:0]       haltExp,
  input  logic                   ebreakHaltEn,
  input  logic                   resetWrite,
  input  logic                   resetHaltWrite,
  input  logic                   resumeReq,
  input  logic [NUM_WARPS-1:0]   selMask,
  input  logic [NUM_WARPS-1:0]   ebreakHit,
  output logic                   sysReset,
  output logic                   resetHaltReq,
  output logic [NUM_WARPS-1:0]   haltedMask,
  output logic [3*NUM_WARPS-1:0] haltCause
);

  seqStrobe_t strobe;

  rst_halt_seq_ctrl uCtrl (
    .dmActive      (dmActive),
    .resetWrite    (resetWrite),
    .resetHaltWrite(resetHaltWrite),
    .resumeReq     (resumeReq),
    .ebreakHaltEn  (ebreakHaltEn),
    .strobe        (strobe)
  );

  rst_halt_seq_dp #(
    .NUM_WARPS(NUM_WARPS),
    .EXP_W    (EXP_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rstExp      (rstExp),
    .haltExp     (haltExp),
    .selMask     (selMask),
    .ebreakHit   (ebreakHit),
    .sysReset    (sysReset),
    .resetHaltReq(resetHaltReq),
    .haltedMask  (haltedMask),
    .haltCause   (haltCause)
  );

endmodule

// File: rtl/rst_halt_seq_chk.sv
module rst_halt_seq_chk #(
  parameter int NUM_WARPS = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   dmActive,
  input logic                   ebreakHaltEn,
  input logic                   resetWrite,
  input logic                   resetHaltWrite,
  input logic [NUM_WARPS-1:0]   ebreakHit,
  input logic                   sysReset,
  input logic                   resetHaltReq,
  input logic [NUM_WARPS-1:0]   haltedMask,
  input logic [3*NUM_WARPS-1:0] haltCause
);

  // R1, R10: a reset pulse only rises after an accepted write
  a_r1_rise_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysReset) |-> $past(resetWrite && dmActive));

  // R4, R3: the halt pulse only rises after a combined write
  a_r4_halt_needs_pair: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetHaltReq) |-> $past(resetWrite && resetHaltWrite && dmActive));

  // R8: dropping the enable silences both pulses
  a_r8_abort: assert property (@(posedge clk) disable iff (!rstN)
    !dmActive |=> (!sysReset && !resetHaltReq));

  for (genvar w = 0; w < NUM_WARPS; w++) begin : gChk
    // R5, R6: a warp halts only under the halt pulse or an enabled breakpoint
    a_r6_halt_source: assert property (@(posedge clk) disable iff (!rstN)
      $rose(haltedMask[w]) |-> $past(resetHaltReq || (ebreakHaltEn && ebreakHit[w])));

    // R9: halted state and cause agree
    a_r9_cause_match: assert property (@(posedge clk) disable iff (!rstN)
      haltedMask[w] == (haltCause[3*w +: 3] != 3'b000));
  end

endmodule

bind rst_halt_seq rst_halt_seq_chk #(.NUM_WARPS(NUM_WARPS)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .dmActive      (dmActive),
  .ebreakHaltEn  (ebreakHaltEn),
  .resetWrite    (resetWrite),
  .resetHaltWrite(resetHaltWrite),
  .ebreakHit     (ebreakHit),
  .sysReset      (sysReset),
  .resetHaltReq  (resetHaltReq),
  .haltedMask    (haltedMask),
  .haltCause     (haltCause)
);

// File: tb/rst_halt_seq_test.sv
module rst_halt_seq_test;

  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          dmActive = 1'b0;
  logic [2:0]    rstExp = '0;
  logic [2:0]    haltExp = '0;
  logic          ebreakHaltEn = 1'b0;
  logic          resetWrite = 1'b0;
  logic          resetHaltWrite = 1'b0;
  logic          resumeReq = 1'b0;
  logic [NW-1:0] selMask = '0;
  logic [NW-1:0] ebreakHit = '0;
  logic          sysReset;
  logic          resetHaltReq;
  logic [NW-1:0] haltedMask;
  logic [3*NW-1:0] haltCause;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rst_halt_seq #(.NUM_WARPS(NW), .EXP_W(3)) uut (
    .clk(clk), .rstN(rstN), .dmActive(dmActive), .rstExp(rstExp),
    .haltExp(haltExp), .ebreakHaltEn(ebreakHaltEn), .resetWrite(resetWrite),
    .resetHaltWrite(resetHaltWrite), .resumeReq(resumeReq), .selMask(selMask),
    .ebreakHit(ebreakHit), .sysReset(sysReset), .resetHaltReq(resetHaltReq),
    .haltedMask(haltedMask), .haltCause(haltCause)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int causesFor(input logic [NW-1:0] m, input int code);
    int r = 0;
    for (int w = 0; w < NW; w++)
      if (m[w]) r |= code << (3*w);
    return r;
  endfunction

  task automatic resumeAll();
    @(negedge clk);
    resumeReq = 1'b1; selMask = '1;
    @(negedge clk);
    resumeReq = 1'b0; selMask = '0;
  endtask

  // issue a write, count how long each pulse is high
  task automatic runPulse(input int rE, input int hE, input bit withHalt,
                          input logic [NW-1:0] sel, output int rc, output int hc,
                          output bit together);
    @(negedge clk);
    rstExp = 3'(rE); haltExp = 3'(hE);
    resetWrite = 1'b1; resetHaltWrite = withHalt; selMask = sel;
    @(negedge clk);
    resetWrite = 1'b0; resetHaltWrite = 1'b0; selMask = '0;
    together = sysReset && resetHaltReq;
    rc = 0; hc = 0;
    for (int i = 0; i < 300; i++) begin
      if (!sysReset && !resetHaltReq) break;
      if (sysReset) rc++;
      if (resetHaltReq) hc++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int rc, hc;
    bit tog;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 sysReset", int'(sysReset), 0);
    check("R11 haltReq", int'(resetHaltReq), 0);
    check("R11 halted", int'(haltedMask), 0);
    check("R11 cause", int'(haltCause), 0);

    // R10 writes ignored while disabled
    runPulse(3, 3, 1'b1, 8'hFF, rc, hc, tog);
    check("R10 no reset pulse", rc, 0);
    check("R10 no halt pulse", hc, 0);
    check("R10 no halt", int'(haltedMask), 0);

    dmActive = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5 sweep over all exponent pairs
    for (int r = 0; r < 8; r++) begin
      for (int h = 0; h < 8; h++) begin
        logic [NW-1:0] sel;
        sel = 8'(r*37 + h*11 + 1);
        runPulse(r, h, 1'b1, sel, rc, hc, tog);
        check("R1 reset length", rc, 1 << r);
        check("R2 halt length", hc, 1 << h);
        check("R3 same start", int'(tog), 1);
        check("R5 halted set", int'(haltedMask), int'(sel));
        check("R5 cause 100", int'(haltCause), causesFor(sel, 4));
        resumeAll();
        check("R9 resumed", int'(haltedMask), 0);
      end
    end

    // R4 halt write alone
    @(negedge clk);
    resetHaltWrite = 1'b1; selMask = 8'hFF; haltExp = 3'd2;
    @(negedge clk);
    resetHaltWrite = 1'b0; selMask = '0;
    check("R4 no halt pulse", int'(resetHaltReq), 0);
    check("R4 no reset pulse", int'(sysReset), 0);
    @(negedge clk);
    check("R4 no halted warp", int'(haltedMask), 0);

    // R4 reset without halt: reset pulse only
    runPulse(2, 5, 1'b0, 8'hFF, rc, hc, tog);
    check("R4 reset only length", rc, 4);
    check("R4 reset only no halt", hc, 0);
    check("R4 reset only no warp", int'(haltedMask), 0);

    // R6 breakpoint enabled then disabled
    @(negedge clk);
    ebreakHaltEn = 1'b1; ebreakHit = 8'h04;
    @(negedge clk);
    ebreakHit = '0;
    check("R6 ebreak halt", int'(haltedMask), 32'h04);
    check("R6 ebreak cause", int'(haltCause), causesFor(8'h04, 1));
    resumeAll();
    ebreakHaltEn = 1'b0; ebreakHit = 8'h81;
    @(negedge clk);
    ebreakHit = '0;
    @(negedge clk);
    check("R6 ebreak disabled", int'(haltedMask), 0);

    // R9 partial resume
    runPulse(0, 0, 1'b1, 8'h0F, rc, hc, tog);
    @(negedge clk);
    resumeReq = 1'b1; selMask = 8'h05;
    @(negedge clk);
    resumeReq = 1'b0; selMask = '0;
    check("R9 partial resume", int'(haltedMask), 32'h0A);
    check("R9 partial cause", int'(haltCause), causesFor(8'h0A, 4));
    resumeAll();

    // R7 restart: 5 cycles of an 8-cycle pulse, then a 4-cycle write
    @(negedge clk);
    rstExp = 3'd3; resetWrite = 1'b1;
    @(negedge clk);
    resetWrite = 1'b0;
    rc = 0;
    for (int i = 0; i < 5; i++) begin
      if (sysReset) rc++;
      if (i < 4) @(negedge clk);
    end
    rstExp = 3'd2; resetWrite = 1'b1;
    @(negedge clk);
    resetWrite = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!sysReset) break;
      rc++;
      @(negedge clk);
    end
    check("R7 restart total", rc, 9);

    // R8 abort mid-pulse
    runPulse(0, 0, 1'b1, 8'h30, rc, hc, tog);
    @(negedge clk);
    rstExp = 3'd7; haltExp = 3'd7; resetWrite = 1'b1; resetHaltWrite = 1'b1;
    selMask = 8'hC0;
    @(negedge clk);
    resetWrite = 1'b0; resetHaltWrite = 1'b0; selMask = '0;
    repeat (3) @(negedge clk);
    check("R8 halted before abort", int'(haltedMask), 32'hF0);
    dmActive = 1'b0;
    @(negedge clk);
    check("R8 reset aborted", int'(sysReset), 0);
    check("R8 halt aborted", int'(resetHaltReq), 0);
    check("R8 halted cleared", int'(haltedMask), 0);
    check("R8 cause cleared", int'(haltCause), 0);
    dmActive = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 stays off", int'(sysReset), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule